// File: doc/BRIEF.md
# TDM Stereo Pair Extractor

This block takes a six-channel time-division-multiplexed audio stream (frame sync plus serial data, one bit per TDM bit clock) and pulls out one chosen stereo pair. The pair is re-sent as a two-channel left-justified serial stream with its own regenerated bit clock and LR clock, ready for a stereo digital audio transmitter. In bypass mode the block instead routes one of three two-channel serial data lines straight to its data output. A separate control bit decides whether the downstream clocks are the converter's own clocks or the ones the block generates.

The block runs on one system clock. The TDM bit clock arrives as a one-cycle strobe `bit_tick` in that domain: frame sync and TDM data are taken only in a cycle where the strobe is high. The generated output clocks are therefore levels that change only on TDM bit strobes, with one output bit lasting four TDM bits. Both streams keep the same frame rate at single, double or quad speed, since everything is counted in TDM bits.

Top module: `tdm_pair_extractor`

## Requirements
- R1: In TDM mode (`tdm_mode`=1), `pair_sel` 00 extracts channels 1 and 2, 01 channels 3 and 4, 10 channels 5 and 6 (first channel of the pair to left, second to right). Channel n occupies TDM slot n-1; slot k covers the 32 TDM bits at positions 32k..32k+31, position 0 being the bit strobe right after the one that carries frame sync; the 24-bit sample sits MSB first in slot positions 0..23, and slot positions 24..31 as well as slots 6 and 7 are ignored.
- R2: The output frame is 64 output bits. Output bits 0..23 carry the left sample MSB first, bits 32..55 the right sample MSB first, and bits 24..31 and 56..63 are zero.
- R3: With generated clocks, output bit b spans TDM positions 4b..4b+3; the bit clock is low for the first two of those positions and high for the last two; the LR clock is high during output bits 0..31 and low during 32..63. A frame sync strobe restarts the output frame at position 0.
- R4: Both samples captured in one TDM frame are transferred together at the frame's last bit and appear during the next frame only, so the output lags by exactly one frame and never mixes two frames.
- R5: `pair_sel`=11 is reserved: the output data is zero in both modes and the output clocks keep running.
- R6: In bypass mode (`tdm_mode`=0), `out_sd` follows `pcm_sd[0]` for select 00, `pcm_sd[1]` for 01 and `pcm_sd[2]` for 10 in the same cycle.
- R7: `clk_src`=0 passes `cnv_bclk`/`cnv_lrck` to `out_bclk`/`out_lrck` in the same cycle; `clk_src`=1 drives them with the generated clocks of R3.
- R8: While `tdm_mode` is low the extractor is unlocked and its held samples are zero; after TDM mode is entered, the output data stays zero until a whole frame bounded by two frame syncs has been captured.
- R9: Synchronous active-low reset clears the held samples and puts the frame position at 0: `out_sd`=0, generated bit clock 0, generated LR clock 1.
- R10: A frame sync strobe that arrives before the frame's last position realigns the position to 0 without transferring the partly captured frame; the previously held pair keeps playing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tdm_mode | input | 1 | 1 = extract from TDM, 0 = bypass |
| pair_sel | input | 2 | Stereo pair / bypass line select, 11 reserved |
| clk_src | input | 1 | 0 = converter clocks out, 1 = generated clocks out |
| bit_tick | input | 1 | One-cycle strobe per TDM bit clock |
| tdm_fs | input | 1 | TDM frame sync, valid with `bit_tick` |
| tdm_sd | input | 1 | TDM serial data, valid with `bit_tick` |
| pcm_sd | input | 3 | Two-channel serial data lines for bypass |
| cnv_bclk | input | 1 | Converter bit clock for pass-through |
| cnv_lrck | input | 1 | Converter LR clock for pass-through |
| out_bclk | output | 1 | Bit clock to the transmitter |
| out_lrck | output | 1 | LR clock to the transmitter |
| out_sd | output | 1 | Serial data to the transmitter |

## Verification
A frame position that drifts from the sync shows within one output bit as a bit clock or LR clock out of phase with the strobes counted since the last sync, and as shifted sample bits in the next frame. A wrong slot decode or a broken double buffer is only visible one frame later, when the played pair carries bits of the wrong channel, of two frames, or of a frame cut short by an early sync. A lock flag that survives leaving TDM mode shows as non-zero data during the first frame after re-entry, and mux faults in bypass or clock selection show in the very cycle the select changes.

// File: rtl/tdm_xtr_pkg.sv
// Package: shared defaults and select encodings for the TDM pair extractor.
// Assumes a two-bit pair select whose highest code is never a valid pair.
package tdm_xtr_pkg;

    localparam int DEF_SAMPLE_W = 24;  // bits per audio sample
    localparam int DEF_SLOT_W   = 32;  // TDM bits per slot
    localparam int DEF_SLOTS    = 8;   // slots per TDM frame
    localparam int DEF_PAIRS    = 3;   // selectable stereo pairs / bypass lines
    localparam int DEF_OUT_DIV  = 4;   // TDM bits per output bit

    typedef enum logic [1:0] {
        PSEL_FIRST  = 2'b00,
        PSEL_SECOND = 2'b01,
        PSEL_THIRD  = 2'b10,
        PSEL_RSVD   = 2'b11
    } pair_sel_e;

    // True when the select code does not name an existing pair.
    function automatic logic sel_reserved(input logic [1:0] sel, input int pairs);
        return int'(sel) >= pairs;
    endfunction

endpackage

// File: rtl/tdm_slot_counter.sv
// Module: TDM frame position counter.
// Counts TDM bit strobes modulo the frame length, restarts on frame sync and
// flags the frame's last bit when a full locked frame has been seen.
// Assumes FRAME_BITS is a power of two, so the counter wraps by itself.
module tdm_slot_counter #(
    parameter int FRAME_BITS = 256,
    localparam int CNT_W     = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             bit_tick,
    input  logic             frame_sync,
    output logic [CNT_W-1:0] pos,
    output logic             frame_done
);

    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS - 1);

    logic locked;

    // Transfer point: last bit of a frame that began at a seen sync.
    assign frame_done = enable && bit_tick && locked && (pos == LAST_POS);

    // Position advance and lock tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos    <= '0;
            locked <= 1'b0;
        end else begin
            if (!enable)
                locked <= 1'b0;
            else if (bit_tick && frame_sync)
                locked <= 1'b1;
            if (bit_tick)
                pos <= frame_sync ? '0 : pos + 1'b1;
        end
    end

    AST_SYNC_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && frame_sync) |=> (pos == '0))
        else $error("frame sync did not restart position"); // R3
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(pos))
        else $error("position moved without a bit strobe"); // R3
    AST_NO_EARLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && frame_sync && pos != LAST_POS) |-> !frame_done)
        else $error("early sync produced a transfer"); // R10

endmodule

// File: rtl/tdm_pair_capture.sv
// Module: stereo pair capture with frame double buffer.
// Shifts the sample bits of the two chosen slots into shadow registers and
// copies both into the held pair only at a locked frame end.
// Assumes the select is steady for the whole frame being captured.
module tdm_pair_capture #(
    parameter int SAMPLE_W  = 24,
    parameter int SLOT_W    = 32,
    parameter int CNT_W     = 8,
    localparam int SLOT_LOG = $clog2(SLOT_W),
    localparam int SIDX_W   = CNT_W - SLOT_LOG
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                bit_tick,
    input  logic                frame_sync,
    input  logic                serial_in,
    input  logic [CNT_W-1:0]    pos,
    input  logic [SIDX_W-1:0]   base_slot,
    input  logic                frame_done,
    output logic [SAMPLE_W-1:0] hold_l,
    output logic [SAMPLE_W-1:0] hold_r
);

    logic [SIDX_W-1:0]   slot_idx;
    logic [SLOT_LOG-1:0] slot_bit;
    logic                in_sample;
    logic                grab_l;
    logic                grab_r;
    logic [SAMPLE_W-1:0] shadow_l;
    logic [SAMPLE_W-1:0] shadow_r;

    assign slot_idx  = pos[CNT_W-1:SLOT_LOG];
    assign slot_bit  = pos[SLOT_LOG-1:0];
    assign in_sample = int'(slot_bit) < SAMPLE_W;
    assign grab_l    = bit_tick && !frame_sync && in_sample && (slot_idx == base_slot);
    assign grab_r    = bit_tick && !frame_sync && in_sample &&
                       (slot_idx == SIDX_W'(base_slot + 1'b1));

    // Shadow shift registers, MSB arrives first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_l <= '0;
            shadow_r <= '0;
        end else begin
            if (grab_l) shadow_l <= {shadow_l[SAMPLE_W-2:0], serial_in};
            if (grab_r) shadow_r <= {shadow_r[SAMPLE_W-2:0], serial_in};
        end
    end

    // Held pair: cleared when unlocked, updated only at a frame end.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            hold_l <= '0;
            hold_r <= '0;
        end else if (frame_done) begin
            hold_l <= shadow_l;
            hold_r <= shadow_r;
        end
    end

    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !frame_done) |=> ($stable(hold_l) && $stable(hold_r)))
        else $error("held pair changed outside a frame end"); // R4
    AST_UNLOCKED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (hold_l == '0 && hold_r == '0))
        else $error("held pair not cleared while unlocked"); // R8

endmodule

// File: rtl/lj_stereo_serializer.sv
// Module: left-justified stereo serializer with clock generation.
// Derives the output bit clock, LR clock and data bit from the shared frame
// position, so the output frame is locked to the TDM frame.
// Assumes OUT_DIV is a power of two and the position spans one frame.
module lj_stereo_serializer #(
    parameter int SAMPLE_W = 24,
    parameter int CNT_W    = 8,
    parameter int OUT_DIV  = 4,
    localparam int DIV_LOG = $clog2(OUT_DIV),
    localparam int OB_W    = CNT_W - DIV_LOG
) (
    input  logic [CNT_W-1:0]    pos,
    input  logic [SAMPLE_W-1:0] hold_l,
    input  logic [SAMPLE_W-1:0] hold_r,
    output logic                gen_bclk,
    output logic                gen_lrck,
    output logic                ser_sd
);

    logic [OB_W-1:0]     out_bit;
    logic [OB_W-2:0]     half_idx;
    logic [SAMPLE_W-1:0] word;
    logic [SAMPLE_W-1:0] aligned;

    assign out_bit  = pos[CNT_W-1:DIV_LOG];
    assign half_idx = out_bit[OB_W-2:0];

    // Clock levels: bit clock high in the second half of each output bit,
    // LR clock high for the left half of the output frame.
    always_comb begin
        gen_bclk = pos[DIV_LOG-1];
        gen_lrck = ~out_bit[OB_W-1];
    end

    // Data bit: MSB-first walk through the active sample, zero in the pad.
    always_comb begin
        word    = gen_lrck ? hold_l : hold_r;
        aligned = word << half_idx;
        ser_sd  = (int'(half_idx) < SAMPLE_W) ? aligned[SAMPLE_W-1] : 1'b0;
    end

endmodule

// File: rtl/tdm_pair_extractor.sv
// Module: TDM stereo pair extractor (top).
// Picks one stereo pair from a six-channel TDM stream and replays it as
// left-justified stereo with generated clocks; in bypass mode routes one of
// the two-channel data lines; selects converter or generated clocks.
// Assumes TDM data and frame sync are synchronous to clk and qualified by
// bit_tick, with frame sync on the last bit of each TDM frame.
module tdm_pair_extractor
    import tdm_xtr_pkg::*;
#(
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int SLOT_W   = DEF_SLOT_W,
    parameter int SLOTS    = DEF_SLOTS,
    parameter int PAIRS    = DEF_PAIRS,
    parameter int OUT_DIV  = DEF_OUT_DIV
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tdm_mode,
    input  logic [1:0]       pair_sel,
    input  logic             clk_src,
    input  logic             bit_tick,
    input  logic             tdm_fs,
    input  logic             tdm_sd,
    input  logic [PAIRS-1:0] pcm_sd,
    input  logic             cnv_bclk,
    input  logic             cnv_lrck,
    output logic             out_bclk,
    output logic             out_lrck,
    output logic             out_sd
);

    localparam int FRAME_BITS = SLOT_W * SLOTS;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam int SIDX_W     = CNT_W - $clog2(SLOT_W);

    logic [CNT_W-1:0]    pos;
    logic                frame_done;
    logic [SAMPLE_W-1:0] hold_l;
    logic [SAMPLE_W-1:0] hold_r;
    logic                gen_bclk;
    logic                gen_lrck;
    logic                ser_sd;
    logic                byp_sd;
    logic                rsvd;
    logic [SIDX_W-1:0]   base_slot;

    assign rsvd      = sel_reserved(pair_sel, PAIRS);
    assign base_slot = SIDX_W'({pair_sel, 1'b0});

    tdm_slot_counter #(.FRAME_BITS(FRAME_BITS)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (tdm_mode),
        .bit_tick   (bit_tick),
        .frame_sync (tdm_fs),
        .pos        (pos),
        .frame_done (frame_done)
    );

    tdm_pair_capture #(
        .SAMPLE_W (SAMPLE_W),
        .SLOT_W   (SLOT_W),
        .CNT_W    (CNT_W)
    ) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (tdm_mode),
        .bit_tick   (bit_tick),
        .frame_sync (tdm_fs),
        .serial_in  (tdm_sd),
        .pos        (pos),
        .base_slot  (base_slot),
        .frame_done (frame_done),
        .hold_l     (hold_l),
        .hold_r     (hold_r)
    );

    lj_stereo_serializer #(
        .SAMPLE_W (SAMPLE_W),
        .CNT_W    (CNT_W),
        .OUT_DIV  (OUT_DIV)
    ) u_ser (
        .pos      (pos),
        .hold_l   (hold_l),
        .hold_r   (hold_r),
        .gen_bclk (gen_bclk),
        .gen_lrck (gen_lrck),
        .ser_sd   (ser_sd)
    );

    // Bypass line selection over the existing lines.
    always_comb begin
        byp_sd = 1'b0;
        for (int i = 0; i < PAIRS; i++)
            if (int'(pair_sel) == i) byp_sd = pcm_sd[i];
    end

    // Output muxes: data by mode and select, clocks by source bit.
    always_comb begin
        out_sd   = rsvd ? 1'b0 : (tdm_mode ? ser_sd : byp_sd);
        out_bclk = clk_src ? gen_bclk : cnv_bclk;
        out_lrck = clk_src ? gen_lrck : cnv_lrck;
    end

    AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_sel == PSEL_RSVD) |-> !out_sd)
        else $error("reserved select produced data"); // R5
    AST_CLK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_src |-> (out_bclk == cnv_bclk && out_lrck == cnv_lrck))
        else $error("converter clocks not passed"); // R7

    for (genvar g = 0; g < PAIRS; g++) begin : g_byp_chk
        AST_BYPASS_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
            (!tdm_mode && int'(pair_sel) == g) |-> (out_sd == pcm_sd[g]))
            else $error("bypass line not routed"); // R6
    end

endmodule

// File: tb/tb_tdm_pair_extractor.sv
`timescale 1ns/1ps
module tb_tdm_pair_extractor;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tdm_mode = 1'b1;
    logic [1:0] pair_sel = 2'b00;
    logic       clk_src = 1'b1;
    logic       bit_tick = 1'b0;
    logic       tdm_fs = 1'b0;
    logic       tdm_sd = 1'b0;
    logic [2:0] pcm_sd = 3'b000;
    logic       cnv_bclk = 1'b0;
    logic       cnv_lrck = 1'b0;
    logic       out_bclk, out_lrck, out_sd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [23:0] smp [6];
    logic        obs_sd [256];
    logic        obs_bc [256];
    logic        obs_lr [256];

    always #2.5 clk = ~clk;

    tdm_pair_extractor dut (
        .clk(clk), .rst_n(rst_n), .tdm_mode(tdm_mode), .pair_sel(pair_sel),
        .clk_src(clk_src), .bit_tick(bit_tick), .tdm_fs(tdm_fs), .tdm_sd(tdm_sd),
        .pcm_sd(pcm_sd), .cnv_bclk(cnv_bclk), .cnv_lrck(cnv_lrck),
        .out_bclk(out_bclk), .out_lrck(out_lrck), .out_sd(out_sd)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Fill the six channel samples from a seed.
    task automatic set_smp(input logic [7:0] seed);
        for (int i = 0; i < 6; i++)
            smp[i] = {seed ^ 8'(i * 37), 8'(i + 1) ^ 8'hA5, seed + 8'(i * 11) + 8'h81};
    endtask

    // TDM bit value at frame position j; filler ones are ignored data (R1).
    function automatic logic bitval(input int j);
        int s = j / 32;
        int b = j % 32;
        if (s < 6 && b < 24) return smp[s][23 - b];
        return (j % 3) == 0;
    endfunction

    // One TDM bit strobe; afterwards the state reflects that strobe.
    task automatic tick_bit(input logic sd, input logic fs);
        @(negedge clk);
        bit_tick = 1'b1; tdm_sd = sd; tdm_fs = fs;
        @(negedge clk);
        bit_tick = 1'b0; tdm_fs = 1'b0;
        #1;
    endtask

    // n filler strobes, the last one carrying frame sync.
    task automatic send_ticks(input int n);
        for (int j = 0; j < n; j++) tick_bit((j % 5) == 1, j == n - 1);
    endtask

    // One TDM frame from smp, sync on its last bit; records the output frame.
    task automatic send_frame();
        obs_sd[0] = out_sd; obs_bc[0] = out_bclk; obs_lr[0] = out_lrck;
        for (int j = 0; j < 256; j++) begin
            tick_bit(bitval(j), j == 255);
            if (j < 255) begin
                obs_sd[j+1] = out_sd; obs_bc[j+1] = out_bclk; obs_lr[j+1] = out_lrck;
            end
        end
    endtask

    // Compare a recorded output frame with the expected pair (R2, R3).
    task automatic check_frame(input string req, input logic [23:0] el, input logic [23:0] er);
        int bad_c = 0, bad_d = 0, first_d = -1;
        logic act_d = 1'b0, exp_d = 1'b0;
        for (int c = 0; c < 256; c++) begin
            int ob = c / 4;
            logic eb = (c % 4) >= 2;
            logic elr = c < 128;
            logic ed = 1'b0;
            if (ob < 24) ed = el[23 - ob];
            else if (ob >= 32 && ob < 56) ed = er[23 - (ob - 32)];
            if (obs_bc[c] !== eb || obs_lr[c] !== elr) bad_c++;
            if (obs_sd[c] !== ed) begin
                if (first_d < 0) begin first_d = c; act_d = obs_sd[c]; exp_d = ed; end
                bad_d++;
            end
        end
        chk({"R3 generated clocks in ", req}, bad_c, 0);
        checks++;
        if (bad_d != 0) begin
            errors++;
            $display("FAIL %s: data bit at position %0d act=%0h exp=%0h (%0d bad)",
                     req, first_d, act_d, exp_d, bad_d);
        end
    endtask

    task automatic t_reset();
        chk("R9 out_sd after reset", out_sd, 0);
        chk("R9 bclk after reset", out_bclk, 0);
        chk("R9 lrck after reset", out_lrck, 1);
    endtask

    task automatic t_pairs();
        logic [23:0] pl, pr;
        pair_sel = 2'b00;
        send_ticks(256);
        smp[0] = 24'hFFFFFF; smp[1] = 24'h800001;
        for (int i = 2; i < 6; i++) smp[i] = 24'h5A5A5A;
        send_frame();
        check_frame("R8 first frame after lock is silent", 24'h0, 24'h0);
        pl = smp[0]; pr = smp[1];
        set_smp(8'h13);
        send_frame();
        check_frame("R1 R2 R4 pair 00", pl, pr);
        pair_sel = 2'b01;
        pl = smp[0]; pr = smp[1];
        set_smp(8'h27);
        send_frame();
        check_frame("R4 pair 00 frame still plays", pl, pr);
        pl = smp[2]; pr = smp[3];
        set_smp(8'h3C);
        send_frame();
        check_frame("R1 pair 01", pl, pr);
        pair_sel = 2'b10;
        set_smp(8'h4E);
        send_frame();
        pl = smp[4]; pr = smp[5];
        set_smp(8'h62);
        send_frame();
        check_frame("R1 pair 10", pl, pr);
    endtask

    task automatic t_reserved();
        pair_sel = 2'b11;
        set_smp(8'h71);
        send_frame();
        send_frame();
        check_frame("R5 reserved select in TDM", 24'h0, 24'h0);
    endtask

    task automatic t_early_sync();
        logic [23:0] pl, pr;
        pair_sel = 2'b00;
        set_smp(8'h85);
        send_frame();
        pl = smp[0]; pr = smp[1];
        set_smp(8'h93);
        send_ticks(100);
        send_frame();
        check_frame("R10 early sync keeps held pair", pl, pr);
        pl = smp[0]; pr = smp[1];
        set_smp(8'hA7);
        send_frame();
        check_frame("R10 frame after realign", pl, pr);
    endtask

    task automatic t_reentry();
        logic [23:0] pl, pr;
        @(negedge clk);
        tdm_mode = 1'b0; pair_sel = 2'b00; pcm_sd = 3'b001;
        repeat (2) @(negedge clk);
        #1 chk("R6 bypass while leaving TDM", out_sd, 1);
        @(negedge clk);
        tdm_mode = 1'b1; pcm_sd = 3'b000;
        #1 chk("R8 held pair cleared on re-entry", out_sd, 0);
        send_ticks(137);
        set_smp(8'hB9);
        send_frame();
        check_frame("R8 silent until full frame", 24'h0, 24'h0);
        pl = smp[0]; pr = smp[1];
        set_smp(8'hC4);
        send_frame();
        check_frame("R8 first full frame after re-entry", pl, pr);
    endtask

    task automatic t_bypass();
        @(negedge clk);
        tdm_mode = 1'b0;
        for (int k = 0; k < 3; k++) begin
            int bad = 0;
            pair_sel = 2'(k);
            for (int v = 0; v < 8; v++) begin
                logic [2:0] pv = 3'(v);
                pcm_sd = pv;
                #1;
                if (out_sd !== pv[k]) bad++;
                @(negedge clk);
            end
            chk($sformatf("R6 bypass line %0d mismatches", k), bad, 0);
        end
        pair_sel = 2'b11;
        pcm_sd = 3'b111;
        #1 chk("R5 reserved select in bypass", out_sd, 0);
    endtask

    task automatic t_clock_src();
        int bad = 0;
        clk_src = 1'b0;
        for (int v = 0; v < 4; v++) begin
            @(negedge clk);
            cnv_bclk = v[0]; cnv_lrck = v[1];
            #1;
            if (out_bclk !== v[0] || out_lrck !== v[1]) bad++;
        end
        chk("R7 converter clocks passed", bad, 0);
        clk_src = 1'b1;
        cnv_bclk = 1'b1; cnv_lrck = 1'b0;
        #1 chk("R7 generated clocks selected", {out_bclk, out_lrck}, {1'b0, 1'b1});
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        set_smp(8'h00);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_pairs();
        t_reserved();
        t_early_sync();
        t_reentry();
        t_bypass();
        t_clock_src();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule